// File: doc/BRIEF.md
# Indexed Interrupt Redirection Table

This block is the register file and request front end of an I/O interrupt router. Software reaches every register through one pair of locations. It first writes a register number into the index register at byte offset 0x00. It then reads or writes the selected 32-bit register through the data window at byte offset 0x10. Behind the window sit an identifier register, a fixed version register and one 64-bit routing entry per input line. Each routing entry is split over two consecutive indices, with the low word at the even index and the high word at the odd one.

Each routing entry holds a vector, a delivery mode, a trigger mode, a mask bit and a destination. When an unmasked input line goes from low to high, the block latches a pending request for that line. It presents the pending request on a valid/ready handshake, labelled with the entry's vector and destination. When several lines are pending, the lowest line number is served first. Delivering the message over a bus, and handling level-triggered acknowledgement, happen outside this block.

Top module: `irq_route_table`

## Requirements
- R1: A write at byte offset 0x00 loads bits 7:0 of the write data into the 8-bit index. A read at offset 0x00 returns the index in bits 7:0 with zeros above it. Any byte offset other than 0x00 and 0x10 reads as zero.
- R2: Index 0x00 is the identifier register. Bits 31:24 are writable, the other bits always read zero, and the register resets to zero.
- R3: Index 0x01 is the version register. It reads bits 23:16 as the number of lines minus one, bits 7:0 as 0x11, and all other bits as zero. Writes to it have no effect.
- R4: For line n, the low word at index 0x10+2n holds the vector in bits 7:0, the delivery mode in bits 10:8, the trigger mode in bit 15 and the mask in bit 16. All other bits read zero.
- R5: For line n, the high word at index 0x11+2n holds the destination in bits 31:24. All other bits read zero.
- R6: After reset, the index is zero and every entry reads with the mask set and all other fields zero, so the low word reads 0x00010000 and the high word reads 0.
- R7: An index in the range 0x02..0x0F, or at or above 0x10+2*N_LINES, reads as zero through the window. A write to such an index changes no register.
- R8: A rising edge on an unmasked line sets that line pending at the same clock edge that first samples the input high. The next cycle then shows req_valid_o high. A line held high raises no further request after it has been accepted.
- R9: An edge on a masked line is ignored. Setting the mask of a pending line drops its request one clock edge after the mask takes effect.
- R10: While requests are pending, req_vector_o and req_dest_o carry the fields of the lowest-numbered pending line. A cycle with req_valid_o and req_ready_i both high retires that line only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Byte offset: 0x00 for the index, 0x10 for the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_i | input | N_LINES | Interrupt input lines, synchronous to clk_i |
| req_valid_o | output | 1 | A request is pending |
| req_ready_i | input | 1 | Downstream accepts the request |
| req_vector_o | output | 8 | Vector of the granted line |
| req_dest_o | output | 8 | Destination of the granted line |

## Verification
The assertions assume that irq_i is already synchronous to clk_i. They also assume that wr_en_i is sampled only at rising edges, with addr_i and wdata_i stable around each edge. The bench meets both assumptions by driving every input on the falling clock edge. It samples the outputs just after that falling edge, so each check sees values settled from the preceding rising edge. Mask and routing changes are made only through the window, so the pending logic always sees a mask that was registered at a clock edge.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam logic [4:0] OFS_INDEX  = 5'h00;
  localparam logic [4:0] OFS_WINDOW = 5'h10;
  localparam logic [7:0] IDX_ID     = 8'h00;
  localparam logic [7:0] IDX_VER    = 8'h01;
  localparam logic [7:0] IDX_BASE   = 8'h10;
  localparam logic [7:0] VER_CODE   = 8'h11;

  typedef struct packed {
    logic       mask;
    logic       trig;
    logic [2:0] dmode;
    logic [7:0] vector;
    logic [7:0] dest;
  } rte_t;

  localparam rte_t RTE_RST = '{mask: 1'b1, trig: 1'b0, dmode: 3'h0, vector: 8'h0, dest: 8'h0};

  function automatic logic [31:0] lo_word(rte_t e);
    return {15'h0, e.mask, e.trig, 4'h0, e.dmode, e.vector};
  endfunction

  function automatic logic [31:0] hi_word(rte_t e);
    return {e.dest, 24'h0};
  endfunction
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned N_LINES = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [4:0]              addr_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  output logic [N_LINES-1:0]      mask_o,
  output logic [N_LINES-1:0][7:0] vector_o,
  output logic [N_LINES-1:0][7:0] dest_o
);
  localparam int unsigned ENT_W   = (N_LINES > 1) ? $clog2(N_LINES) : 1;
  localparam int unsigned TOP_IDX = 32'(IDX_BASE) + 2 * N_LINES;
  localparam logic [7:0]  MAX_ENT = 8'(N_LINES - 1);

  logic [7:0] idx_q, id_q, rel;
  rte_t       tbl_q [N_LINES];
  logic       in_tbl, wr_idx, wr_win;
  logic [ENT_W-1:0] ent;
  logic [31:0] win_data;

  assign rel    = idx_q - IDX_BASE;
  assign in_tbl = (idx_q >= IDX_BASE) && (32'(idx_q) < TOP_IDX);
  assign ent    = rel[ENT_W:1];
  assign wr_idx = wr_en_i && (addr_i == OFS_INDEX);
  assign wr_win = wr_en_i && (addr_i == OFS_WINDOW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      id_q  <= '0;
      for (int i = 0; i < N_LINES; i++) tbl_q[i] <= RTE_RST;
    end else begin
      if (wr_idx) idx_q <= wdata_i[7:0];
      if (wr_win) begin
        if (idx_q == IDX_ID) begin
          id_q <= wdata_i[31:24];
        end else if (in_tbl) begin
          if (rel[0]) begin
            tbl_q[ent].dest <= wdata_i[31:24];
          end else begin
            tbl_q[ent].mask   <= wdata_i[16];
            tbl_q[ent].trig   <= wdata_i[15];
            tbl_q[ent].dmode  <= wdata_i[10:8];
            tbl_q[ent].vector <= wdata_i[7:0];
          end
        end
      end
    end
  end

  always_comb begin
    win_data = '0;
    if (idx_q == IDX_ID)       win_data = {id_q, 24'h0};
    else if (idx_q == IDX_VER) win_data = {8'h0, MAX_ENT, 8'h0, VER_CODE};
    else if (in_tbl)           win_data = rel[0] ? hi_word(tbl_q[ent]) : lo_word(tbl_q[ent]);
  end

  always_comb begin
    case (addr_i)
      OFS_INDEX:  rdata_o = {24'h0, idx_q};
      OFS_WINDOW: rdata_o = win_data;
      default:    rdata_o = '0;
    endcase
  end

  for (genvar g = 0; g < N_LINES; g++) begin : g_out
    assign mask_o[g]   = tbl_q[g].mask;
    assign vector_o[g] = tbl_q[g].vector;
    assign dest_o[g]   = tbl_q[g].dest;
  end

  // R1
  a_r1_index_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_idx |=> idx_q == $past(wdata_i[7:0]));
  // R7: a window write outside the table and ID register leaves every mask as it was
  a_r7_oor_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_win && !in_tbl && idx_q != IDX_ID) |=> $stable(mask_o));
endmodule

// File: rtl/irq_route_edge.sv
module irq_route_edge #(
  parameter int unsigned N_LINES = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic [N_LINES-1:0] ack_i,
  output logic [N_LINES-1:0] pending_o
);
  logic [N_LINES-1:0] prev_q, pend_q, rise;

  assign rise = irq_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= irq_i;
      // a new edge outranks a same-cycle acknowledge; the mask outranks both
      pend_q <= ((pend_q & ~ack_i) | rise) & ~mask_i;
    end
  end

  assign pending_o = pend_q;

  // R8
  a_r8_edge_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(rise & ~mask_i)) |=> ((pend_q & $past(rise & ~mask_i)) == $past(rise & ~mask_i)));
  // R9
  a_r9_masked_not_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & $past(mask_i)) == '0);
endmodule

// File: rtl/irq_route_arb.sv
module irq_route_arb #(
  parameter int unsigned N_LINES = 24
) (
  input  logic [N_LINES-1:0]         pending_i,
  output logic [N_LINES-1:0]         grant_o,
  output logic [$clog2(N_LINES)-1:0] idx_o,
  output logic                       valid_o
);
  localparam int unsigned IW = $clog2(N_LINES);

  assign grant_o = pending_i & (~pending_i + 1'b1);
  assign valid_o = |pending_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N_LINES; i++)
      if (grant_o[i]) idx_o = IW'(i);
  end

  // R10
  always_comb begin
    a_r10_grant_onehot: assert ($onehot0(grant_o));
    a_r10_grant_lowest: assert (((grant_o - 1'b1) & pending_i) == '0 || !valid_o);
  end
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
  import irq_route_pkg::*;
#(
  parameter int unsigned N_LINES = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [4:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [N_LINES-1:0] irq_i,
  output logic               req_valid_o,
  input  logic               req_ready_i,
  output logic [7:0]         req_vector_o,
  output logic [7:0]         req_dest_o
);
  localparam int unsigned IW = $clog2(N_LINES);

  logic [N_LINES-1:0]      mask, pending, grant, ack;
  logic [N_LINES-1:0][7:0] vector, dest;
  logic [IW-1:0]           gidx;

  irq_route_regs #(.N_LINES(N_LINES)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .mask_o(mask), .vector_o(vector), .dest_o(dest)
  );

  irq_route_edge #(.N_LINES(N_LINES)) u_edge (
    .clk_i, .rst_ni, .irq_i, .mask_i(mask), .ack_i(ack), .pending_o(pending)
  );

  irq_route_arb #(.N_LINES(N_LINES)) u_arb (
    .pending_i(pending), .grant_o(grant), .idx_o(gidx), .valid_o(req_valid_o)
  );

  assign ack          = grant & {N_LINES{req_valid_o & req_ready_i}};
  assign req_vector_o = vector[gidx];
  assign req_dest_o   = dest[gidx];

  // R10: the accepted line is retired unless a fresh edge arrived on it
  a_r10_ack_retires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ready_i && !(|(grant & irq_i))) |=> ((pending & $past(grant)) == '0));
endmodule

// File: tb/tb_irq_route_table.sv
module tb_irq_route_table;
  localparam int unsigned N = 24;

  typedef struct packed {
    logic        wr;
    logic [7:0]  idx;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 32'h0,        32'h00000000},  // R2 reset
    '{1'b1, 8'h00, 32'hA5FFFFFF, 32'hA5000000},  // R2
    '{1'b0, 8'h01, 32'h0,        32'h00170011},  // R3
    '{1'b1, 8'h01, 32'hFFFFFFFF, 32'h00170011},  // R3 write ignored
    '{1'b0, 8'h10, 32'h0,        32'h00010000},  // R6
    '{1'b0, 8'h11, 32'h0,        32'h00000000},  // R6
    '{1'b0, 8'h3E, 32'h0,        32'h00010000},  // R6 last entry
    '{1'b1, 8'h10, 32'hFFFFFFFF, 32'h000187FF},  // R4
    '{1'b1, 8'h12, 32'h00008245, 32'h00008245},  // R4
    '{1'b1, 8'h11, 32'hFFFFFFFF, 32'hFF000000},  // R5
    '{1'b1, 8'h3F, 32'h12345678, 32'h12000000},  // R5
    '{1'b1, 8'h05, 32'h12345678, 32'h00000000},  // R7
    '{1'b1, 8'h40, 32'hFFFFFFFF, 32'h00000000},  // R7
    '{1'b1, 8'hFF, 32'hFFFFFFFF, 32'h00000000}   // R7
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, ready = 1'b0;
  logic [4:0]   addr = '0;
  logic [31:0]  wdata = '0, rdata;
  logic [N-1:0] irq = '0;
  logic         valid;
  logic [7:0]   vec, dst;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  irq_route_table #(.N_LINES(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_i(irq), .req_valid_o(valid), .req_ready_i(ready),
    .req_vector_o(vec), .req_dest_o(dst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic win_wr(input logic [7:0] i, input logic [31:0] d);
    bus_wr(5'h00, {24'h0, i});
    bus_wr(5'h10, d);
  endtask

  task automatic win_rd(input logic [7:0] i, output logic [31:0] d);
    bus_wr(5'h00, {24'h0, i});
    bus_rd(5'h10, d);
  endtask

  task automatic accept_one();
    @(negedge clk);
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    bus_rd(5'h00, d);
    check("R6 index reset", d, 32'h0);
    check("R8 no request after reset", {31'h0, valid}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      if (VECS[k].wr) win_wr(VECS[k].idx, VECS[k].data);
      win_rd(VECS[k].idx, d);
      check($sformatf("table row %0d (R2-R7 per row)", k), d, VECS[k].exp);
    end

    // R7: the out-of-range writes above must not have reached entry 0
    win_rd(8'h10, d);
    check("R7 entry 0 untouched", d, 32'h000187FF);

    // R1
    bus_wr(5'h00, 32'hFFFFFF3E);
    bus_rd(5'h00, d);
    check("R1 index readback", d, 32'h0000003E);
    bus_rd(5'h04, d);
    check("R1 unused offset", d, 32'h0);

    // routing: lines 3 and 5 unmasked, line 7 masked
    win_wr(8'h16, 32'h00000033);
    win_wr(8'h17, 32'h83000000);
    win_wr(8'h1A, 32'h00000055);
    win_wr(8'h1B, 32'h85000000);
    win_wr(8'h1E, 32'h00010077);
    win_wr(8'h1F, 32'h87000000);

    @(negedge clk);
    irq[3] = 1'b1; irq[5] = 1'b1; irq[7] = 1'b1;
    @(negedge clk);
    check("R8 valid after edge", {31'h0, valid}, 32'h1);
    check("R10 lowest first vector", {24'h0, vec}, 32'h33);
    check("R10 lowest first dest", {24'h0, dst}, 32'h83);
    @(negedge clk);
    check("R10 held without ready", {24'h0, vec}, 32'h33);

    accept_one();
    check("R10 next line vector", {24'h0, vec}, 32'h55);
    check("R10 next line dest", {24'h0, dst}, 32'h85);
    accept_one();
    check("R9 masked line never requests", {31'h0, valid}, 32'h0);
    repeat (3) @(negedge clk);
    check("R8 held level no repeat", {31'h0, valid}, 32'h0);

    irq[5] = 1'b0;
    @(negedge clk);
    irq[5] = 1'b1;
    @(negedge clk);
    check("R8 second edge", {24'h0, vec}, 32'h55);
    win_wr(8'h1A, 32'h00010055);
    @(negedge clk);
    check("R9 mask drops pending", {31'h0, valid}, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule